// File: doc/BRIEF.md
# Instruction-Driven Barrel Shifter

This block is a purely combinational 32-bit shifter for a RISC-style integer datapath. It takes the raw R-type instruction word and the two source operand values. From these it produces the shifted result and a flag that marks the function code as one of the six supported shifts. The value to shift always comes from the second source operand (rt). The count comes from one of two places:

- the 5-bit immediate count field of the instruction, or
- the low five bits of the first source operand (rs).

The function code decides which source supplies the count, the shift direction, and whether the fill is zeros or copies of the sign bit.

Internally, a decoder turns the function code into control fields, and a selector picks the count. A logarithmic shifter core does right shifts with a chosen fill bit. It does left shifts by reversing the bit order on the way in and on the way out.

Top module: `bshift_unit`

## Requirements
- R1: Function code is instruction bits 5:0. Codes 0x00 (left, immediate count), 0x02 (logical right, immediate count), 0x03 (arithmetic right, immediate count), 0x04 (left, register count), 0x06 (logical right, register count) and 0x07 (arithmetic right, register count) drive `valid_o` high.
- R2: Any other function code drives `valid_o` low and `result_o` to zero.
- R3: For codes 0x00, 0x02 and 0x03 the count is instruction bits 10:6.
- R4: For codes 0x04, 0x06 and 0x07 the count is `rs_val_i[4:0]`, and `rs_val_i[31:5]` has no effect on the result.
- R5: Left shifts fill the vacated low bits with zeros (3 shifted left by 2 gives 12).
- R6: Logical right shifts fill the vacated high bits with zeros (16 shifted right by 2 gives 4; 0x80000001 by 2 gives 0x20000000).
- R7: Arithmetic right shifts fill the vacated high bits with `rt_val_i[31]` (0x80000001 by 2 gives 0xE0000000).
- R8: A count of zero returns `rt_val_i` unchanged for every valid code.
- R9: The shifted value is always `rt_val_i`; for immediate-count codes `rs_val_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | R-type instruction word (function code and count field) |
| rs_val_i | input | 32 | First source operand; its low bits give the register count |
| rt_val_i | input | 32 | Second source operand; the value that is shifted |
| result_o | output | 32 | Shifted value, zero when the code is unsupported |
| valid_o | output | 1 | High when the function code is one of the six shifts |

## Verification
A vector table checks the worked examples: small left and right shifts, and 0x80000001 shifted right by two under both fills. These separate the zero fill from the sign fill.

Full sweeps of every count from 0 to 31 for all six codes run on two complementary bit patterns. One has its sign bit set and one does not. These sweeps expose wrong stage wiring, a lost count bit, or a fill that ignores the sign.

Register-count cases put random bits above rs bit 4, and immediate-count cases put nonzero values in rs. This shows the count comes only from the source each code selects. A sweep over all 64 function codes confirms that exactly six are accepted and that every other code yields zero.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned FUNCT_LSB = 0;
  localparam int unsigned FUNCT_W   = 6;
  localparam int unsigned SHAMT_LSB = 6;

  typedef enum logic [FUNCT_W-1:0] {
    OP_SLL  = 6'h00,
    OP_SRL  = 6'h02,
    OP_SRA  = 6'h03,
    OP_SLLV = 6'h04,
    OP_SRLV = 6'h06,
    OP_SRAV = 6'h07
  } shift_op_e;

  typedef struct packed {
    logic valid;
    logic dir_left;
    logic arith;
    logic amt_var;
  } shift_ctl_t;
endpackage

// File: rtl/bshift_dec.sv
module bshift_dec
  import bshift_pkg::*;
(
  input  logic [FUNCT_W-1:0] funct_i,
  output shift_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (funct_i)
      OP_SLL:  ctl_o = '{valid: 1'b1, dir_left: 1'b1, arith: 1'b0, amt_var: 1'b0};
      OP_SRL:  ctl_o = '{valid: 1'b1, dir_left: 1'b0, arith: 1'b0, amt_var: 1'b0};
      OP_SRA:  ctl_o = '{valid: 1'b1, dir_left: 1'b0, arith: 1'b1, amt_var: 1'b0};
      OP_SLLV: ctl_o = '{valid: 1'b1, dir_left: 1'b1, arith: 1'b0, amt_var: 1'b1};
      OP_SRLV: ctl_o = '{valid: 1'b1, dir_left: 1'b0, arith: 1'b0, amt_var: 1'b1};
      OP_SRAV: ctl_o = '{valid: 1'b1, dir_left: 1'b0, arith: 1'b1, amt_var: 1'b1};
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/bshift_amt.sv
module bshift_amt #(
  parameter int unsigned AMT_W = 5
) (
  input  logic             amt_var_i,
  input  logic [AMT_W-1:0] shamt_i,
  input  logic [AMT_W-1:0] rs_low_i,
  output logic [AMT_W-1:0] amt_o
);
  assign amt_o = amt_var_i ? rs_low_i : shamt_i;
endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rev_in, pre, post_rev;
  logic [DATA_W-1:0] stg [AMT_W+1];
  logic              fill;

  // left shift = reverse, shift right, reverse
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
    assign rev_in[i] = data_i[DATA_W-1-i];
  end

  assign pre    = left_i ? rev_in : data_i;
  assign fill   = arith_i & ~left_i & data_i[DATA_W-1];
  assign stg[0] = pre;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{STEP{fill}}, stg[k][DATA_W-1:STEP]} : stg[k];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
    assign post_rev[i] = stg[AMT_W][DATA_W-1-i];
  end

  assign data_o = left_i ? post_rev : stg[AMT_W];
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               valid_o
);
  localparam int unsigned AMT_W = $clog2(DATA_W);

  shift_ctl_t        ctl;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;
  logic              unused_bits;

  assign unused_bits = ^{instr_i[INSTR_W-1:SHAMT_LSB+AMT_W], rs_val_i[DATA_W-1:AMT_W]};

  bshift_dec u_dec (
    .funct_i (instr_i[FUNCT_LSB +: FUNCT_W]),
    .ctl_o   (ctl)
  );

  bshift_amt #(.AMT_W(AMT_W)) u_amt (
    .amt_var_i (ctl.amt_var),
    .shamt_i   (instr_i[SHAMT_LSB +: AMT_W]),
    .rs_low_i  (rs_val_i[AMT_W-1:0]),
    .amt_o     (amt)
  );

  bshift_core #(.DATA_W(DATA_W)) u_core (
    .data_i  (rt_val_i),
    .amt_i   (amt),
    .left_i  (ctl.dir_left),
    .arith_i (ctl.arith),
    .data_o  (shifted)
  );

  assign result_o = ctl.valid ? shifted : '0;
  assign valid_o  = ctl.valid;
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk
  import bshift_pkg::*;
(
  input logic [31:0] instr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic [31:0] result_o,
  input logic        valid_o
);
  logic [5:0] fn;
  logic [4:0] cnt;
  logic       known, is_left, is_lright, is_aright;
  logic       unused_chk;

  assign unused_chk = ^{instr_i[31:11], rs_val_i[31:5]};
  assign fn         = instr_i[5:0];
  assign known      = fn inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
  assign cnt        = fn[2] ? rs_val_i[4:0] : instr_i[10:6];
  assign is_left    = known && fn[1:0] == 2'b00;
  assign is_lright  = known && fn[1:0] == 2'b10;
  assign is_aright  = known && fn[1:0] == 2'b11;

  always_comb begin
    // R1
    funct_decode_chk: assert (valid_o == known);
    // R2
    invalid_zero_chk: assert (valid_o || result_o == 32'h0);
    // R8
    if (known && cnt == 5'd0) zero_amt_chk: assert (result_o == rt_val_i);
    // R5
    if (is_left && cnt != 5'd0) left_fill_chk: assert (result_o[0] == 1'b0);
    // R6
    if (is_lright && cnt != 5'd0) lright_fill_chk: assert (result_o[31] == 1'b0);
    // R7
    if (is_aright) aright_sign_chk: assert (result_o[31] == rt_val_i[31]);
  end
endmodule

bind bshift_unit bshift_chk u_chk (
  .instr_i  (instr_i),
  .rs_val_i (rs_val_i),
  .rt_val_i (rt_val_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/bshift_unit_tb.sv
module bshift_unit_tb;
  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [31:0] exp;
    logic        vld;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0004_1080, 32'h0,         32'h3,         32'hC,         1'b1}, // R5 R3 sll 2
    '{32'h0000_0006, 32'h2,         32'h10,        32'h4,         1'b1}, // R6 R4 srlv 2
    '{32'h0000_0083, 32'h0,         32'h8000_0001, 32'hE000_0000, 1'b1}, // R7 sra 2
    '{32'h0000_0007, 32'h2,         32'h8000_0001, 32'hE000_0000, 1'b1}, // R7 srav 2
    '{32'h0000_0082, 32'h0,         32'h8000_0001, 32'h2000_0000, 1'b1}, // R6 srl 2
    '{32'h0000_0004, 32'hFFFF_FFE4, 32'h1,         32'h10,        1'b1}, // R4 sllv high rs bits
    '{32'h0000_0000, 32'h0,         32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1}, // R8 sll 0
    '{32'h0000_0007, 32'h20,        32'h8000_0000, 32'h8000_0000, 1'b1}, // R8 R4 srav rs=32
    '{32'h0000_07C3, 32'h0,         32'h8000_0000, 32'hFFFF_FFFF, 1'b1}, // R7 sra 31
    '{32'h0000_07C2, 32'h0,         32'h8000_0000, 32'h1,         1'b1}, // R6 srl 31
    '{32'h0000_0140, 32'hFFFF_FFFF, 32'h1,         32'h20,        1'b1}, // R9 sll 5 rs ignored
    '{32'h0000_0103, 32'h0,         32'h7FFF_FFF0, 32'h07FF_FFFF, 1'b1}, // R7 positive sra 4
    '{32'h0000_0081, 32'h2,         32'hFFFF_FFFF, 32'h0,         1'b0}, // R2 funct 1
    '{32'h0000_0085, 32'h2,         32'hFFFF_FFFF, 32'h0,         1'b0}, // R2 funct 5
    '{32'h0000_0008, 32'h2,         32'hFFFF_FFFF, 32'h0,         1'b0}, // R2 funct 8
    '{32'h0000_07C0, 32'h3,         32'hFFFF_FFFF, 32'h8000_0000, 1'b1}  // R3 sll 31
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr, rs_v, rt_v, res;
  logic        vld;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4ns clk = ~clk;

  bshift_unit u_dut (
    .instr_i  (instr),
    .rs_val_i (rs_v),
    .rt_val_i (rt_v),
    .result_o (res),
    .valid_o  (vld)
  );

  function automatic logic [32:0] ref_shift(logic [31:0] ins, logic [31:0] rs, logic [31:0] rt);
    logic [4:0] c;
    logic [5:0] f;
    f = ins[5:0];
    c = f[2] ? rs[4:0] : ins[10:6];
    case (f)
      6'h00, 6'h04: return {1'b1, rt << c};
      6'h02, 6'h06: return {1'b1, rt >> c};
      6'h03, 6'h07: return {1'b1, 32'($signed(rt) >>> c)};
      default:      return 33'h0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [31:0] rs, input logic [31:0] rt,
                       input logic [31:0] exp, input logic ev, input string tag);
    @(negedge clk);
    instr = ins; rs_v = rs; rt_v = rt;
    #1ns;
    n_chk++;
    if (res !== exp || vld !== ev) begin
      n_bad++;
      $display("FAIL %s instr=%h rs=%h rt=%h: got %h/%b exp %h/%b",
               tag, ins, rs, rt, res, vld, exp, ev);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [32:0] r;
    logic [5:0]  ops [6] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
    logic [31:0] pats [2] = '{32'hA5C3_0F96, 32'h5A3C_F069};
    instr = '0; rs_v = '0; rt_v = '0;
    repeat (3) @(posedge clk);
    // reset state: zero instr is sll by 0 of zero (R1, R8)
    apply(32'h0, 32'h0, 32'h0, 32'h0, 1'b1, "R1 reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(VECS[i].instr, VECS[i].rs, VECS[i].rt, VECS[i].exp, VECS[i].vld, "R1 table");

    // count sweeps: R3 immediate, R4 register with junk upper rs bits, R5 R6 R7
    for (int o = 0; o < 6; o++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 32; a++) begin
          logic [31:0] ins, rs;
          if (ops[o][2]) begin
            ins = {21'h0, 5'd31 - 5'(a), ops[o]};
            rs  = {27'($urandom), 5'(a)};
          end else begin
            ins = {21'h1F_F00, 5'(a), ops[o]};
            rs  = $urandom;
          end
          r = ref_shift(ins, rs, pats[p]);
          apply(ins, rs, pats[p], r[31:0], r[32], ops[o][2] ? "R4 sweep" : "R3 R9 sweep");
        end

    // R1 R2: every function code
    for (int f = 0; f < 64; f++) begin
      logic [31:0] ins;
      ins = {21'h0, 5'd3, 6'(f)};
      r = ref_shift(ins, 32'h1, 32'hF00D_CAFE);
      apply(ins, 32'h1, 32'hF00D_CAFE, r[31:0], r[32], "R2 funct sweep");
    end

    // R8 zero count for register forms with nonzero upper rs
    apply(32'h0000_07C6, 32'hFFFF_FFE0, 32'h1234_5678, 32'h1234_5678, 1'b1, "R8 srlv 0");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule